// File: doc/BRIEF.md
# Packet Deframer and Checker

This block sits at the receiving end of a serial link that carries two video streams and one audio stream. The stream is a sequence of byte-wide beats, and each packet in it is framed by start and end markers. The block reads the header of each packet, counts out the payload by the length the header declares, and checks the packet's trailing checksum. Payload bytes are passed straight on to one of three sinks (left video, right video or audio), chosen by the header's type code.

At the end of every packet the block gives a one-cycle verdict pulse with error flags. A sink that has already taken the streamed bytes uses this pulse to drop a bad packet. The checks are meant to expose gross design faults upstream, such as lost bytes, FIFOs read while empty, or a length field that does not match the data actually sent. Three sticky saturating counters tally checksum faults, framing faults and unrecognised types, and a synchronous clear input resets them to zero.

Top module: `deframe_checker`

## Requirements
- R1: A packet is a beat with `in_sop` high whose byte is the type code, then a length beat holding N (0 to 255), then N payload beats, then a checksum beat with `in_eop` high. A beat counts only while `in_valid` is high.
- R2: Type code 0x01 routes payload to the left outputs, 0x02 to the right outputs and 0x03 to the audio outputs. Each payload byte appears on its sink's data output with that sink's valid strobe high for one cycle, one cycle after the beat is taken. At most one strobe is high at a time.
- R3: Any other type code produces no payload strobes. At its checksum beat it raises `res_err_type`.
- R4: The 8-bit modulo-256 sum of the type, length, payload and checksum bytes must be zero. Otherwise the packet's verdict raises `res_err_sum`.
- R5: `res_valid` pulses for one cycle, one cycle after the beat that ends a packet. `res_good` is high in that cycle exactly when none of the three error flags is set.
- R6: A beat with `in_sop` that arrives while a packet is open ends that packet with `res_err_frame`. Without `in_eop`, the same beat starts a new packet as its type byte. With `in_eop`, the parser returns to idle.
- R7: An `in_eop` on a type, length or payload beat ends the packet with `res_err_frame`, and that byte is not streamed to a sink. A beat with both `in_sop` and `in_eop` seen while idle also gives a frame-error verdict.
- R8: A checksum beat without `in_eop` ends the packet with `res_err_frame`. The parser goes idle, and beats without `in_sop` that follow are discarded.
- R9: Beats that arrive while idle without `in_sop` are ignored. They produce no strobe and no verdict, and they leave the counters unchanged.
- R10: `cnt_sum_err`, `cnt_frame_err` and `cnt_type_err` each rise by one for every verdict that carries their flag. They stop at 65535.
- R11: `cnt_clr` zeroes all three counters on the next clock edge, and it takes precedence over an increment due on that same edge.
- R12: After reset every strobe and verdict output is low and every counter reads zero.
- R13: A length of zero takes the parser straight from the length beat to the checksum beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Beat is the first byte of a packet |
| in_eop | input | 1 | Beat is the last byte of a packet |
| cnt_clr | input | 1 | Synchronous clear of the error counters |
| left_valid | output | 1 | Left video payload strobe |
| left_data | output | 8 | Left video payload byte |
| right_valid | output | 1 | Right video payload strobe |
| right_data | output | 8 | Right video payload byte |
| audio_valid | output | 1 | Audio payload strobe |
| audio_data | output | 8 | Audio payload byte |
| res_valid | output | 1 | Packet verdict pulse |
| res_good | output | 1 | Packet passed every check |
| res_err_sum | output | 1 | Checksum mismatch |
| res_err_frame | output | 1 | Framing fault |
| res_err_type | output | 1 | Unrecognised type code |
| cnt_sum_err | output | 16 | Checksum fault count |
| cnt_frame_err | output | 16 | Framing fault count |
| cnt_type_err | output | 16 | Unknown type count |

## Verification
The bench targets the following corner cases, each paired with the failure a faulty design would show:

- **Zero-length and 255-length packets.** A design whose length counter is off by one would eat the checksum as payload or wait for one byte too many.
- **A start marker in the middle of a packet, and end markers that come early or not at all.** A wrong framing state machine would stay stuck in a packet or drop the packet that follows.
- **Stray bytes while idle, and unknown types with good and bad checksums.** A leaky router would send bytes to a sink that should get none.
- **Counter limits.** The bench drives more than 65535 framing faults back to back to show that the counter saturates instead of wrapping. It also raises the clear on the very edge where an increment is due, so a design that lets the increment win is caught.

// File: rtl/deframe_pkg.sv
package deframe_pkg;

  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CODE_LEFT  = 8'h01;
  localparam byte_t CODE_RIGHT = 8'h02;
  localparam byte_t CODE_AUDIO = 8'h03;

  localparam int NUM_SINKS = 3;
  localparam int NUM_ERRS  = 3;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LEN     = 2'd1,
    ST_PAYLOAD = 2'd2,
    ST_CHECK   = 2'd3
  } parse_state_t;

  typedef enum logic [1:0] {
    SINK_LEFT  = 2'd0,
    SINK_RIGHT = 2'd1,
    SINK_AUDIO = 2'd2,
    SINK_NONE  = 2'd3
  } sink_t;

  function automatic sink_t sink_of(byte_t code);
    case (code)
      CODE_LEFT:  return SINK_LEFT;
      CODE_RIGHT: return SINK_RIGHT;
      CODE_AUDIO: return SINK_AUDIO;
      default:    return SINK_NONE;
    endcase
  endfunction

  function automatic byte_t sum_add(byte_t acc, byte_t b);
    return byte_t'(acc + b);
  endfunction

endpackage

// File: rtl/deframe_parser.sv
module deframe_parser
  import deframe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  byte_t  in_data,
  input  logic   in_sop,
  input  logic   in_eop,
  output logic   pay_fire,
  output sink_t  pay_sink,
  output byte_t  pay_byte,
  output logic   res_valid,
  output logic   res_good,
  output logic   res_err_sum,
  output logic   res_err_frame,
  output logic   res_err_type
);

  parse_state_t st_q, st_n;
  byte_t        typ_q, typ_n;
  byte_t        rem_q, rem_n;
  byte_t        acc_q, acc_n;

  // named events for assertions
  logic ev_fin, ev_frame, ev_sum, ev_type;

  always_comb begin
    st_n     = st_q;
    typ_n    = typ_q;
    rem_n    = rem_q;
    acc_n    = acc_q;
    ev_fin   = 1'b0;
    ev_frame = 1'b0;
    ev_sum   = 1'b0;
    ev_type  = 1'b0;
    pay_fire = 1'b0;
    if (in_valid) begin
      if (in_sop) begin
        if (st_q != ST_IDLE || in_eop) begin
          ev_fin   = 1'b1;
          ev_frame = 1'b1;
        end
        if (in_eop) begin
          st_n = ST_IDLE;
        end else begin
          st_n  = ST_LEN;
          typ_n = in_data;
          acc_n = in_data;
        end
      end else begin
        case (st_q)
          ST_LEN: begin
            if (in_eop) begin
              ev_fin   = 1'b1;
              ev_frame = 1'b1;
              st_n     = ST_IDLE;
            end else begin
              rem_n = in_data;
              acc_n = sum_add(acc_q, in_data);
              st_n  = (in_data == '0) ? ST_CHECK : ST_PAYLOAD;
            end
          end
          ST_PAYLOAD: begin
            if (in_eop) begin
              ev_fin   = 1'b1;
              ev_frame = 1'b1;
              st_n     = ST_IDLE;
            end else begin
              pay_fire = (sink_of(typ_q) != SINK_NONE);
              acc_n    = sum_add(acc_q, in_data);
              rem_n    = byte_t'(rem_q - 1'b1);
              if (rem_q == byte_t'(1)) st_n = ST_CHECK;
            end
          end
          ST_CHECK: begin
            ev_fin = 1'b1;
            st_n   = ST_IDLE;
            if (!in_eop) begin
              ev_frame = 1'b1;
            end else begin
              ev_sum  = (sum_add(acc_q, in_data) != '0);
              ev_type = (sink_of(typ_q) == SINK_NONE);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pay_sink = sink_of(typ_q);
  assign pay_byte = in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      typ_q         <= '0;
      rem_q         <= '0;
      acc_q         <= '0;
      res_valid     <= 1'b0;
      res_good      <= 1'b0;
      res_err_sum   <= 1'b0;
      res_err_frame <= 1'b0;
      res_err_type  <= 1'b0;
    end else begin
      st_q          <= st_n;
      typ_q         <= typ_n;
      rem_q         <= rem_n;
      acc_q         <= acc_n;
      res_valid     <= ev_fin;
      res_good      <= ev_fin & ~(ev_frame | ev_sum | ev_type);
      res_err_sum   <= ev_sum;
      res_err_frame <= ev_frame;
      res_err_type  <= ev_type;
    end
  end

  // R8: a checksum beat always closes the packet on the next cycle
  assert_check_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && in_valid) |=> (res_valid && st_q != ST_CHECK));

  // R13: zero length skips the payload state
  assert_zero_len_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LEN && in_valid && !in_sop && !in_eop && in_data == '0) |=> (st_q == ST_CHECK));

  // R5: a verdict only follows a taken beat, and a good verdict has no flags
  assert_verdict_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(in_valid) && !(res_good && (res_err_sum || res_err_frame || res_err_type))));

  // R6: a start marker in an open packet yields a frame error verdict
  assert_sop_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && st_q != ST_IDLE) |=> (res_valid && res_err_frame));

endmodule

// File: rtl/deframe_router.sv
module deframe_router
  import deframe_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pay_fire,
  input  sink_t                 pay_sink,
  input  byte_t                 pay_byte,
  output logic [NUM_SINKS-1:0]  sink_valid,
  output byte_t                 sink_data [NUM_SINKS]
);

  for (genvar g = 0; g < NUM_SINKS; g++) begin : g_sink
    logic hit;
    assign hit = pay_fire && (pay_sink == sink_t'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sink_valid[g] <= 1'b0;
        sink_data[g]  <= '0;
      end else begin
        sink_valid[g] <= hit;
        if (hit) sink_data[g] <= pay_byte;
      end
    end
  end

  // R2: never more than one sink strobed
  assert_one_sink_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sink_valid));

  // R3: a strobe implies a routed payload beat one cycle earlier
  assert_strobe_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_valid != '0) |-> $past(pay_fire));

endmodule

// File: rtl/deframe_sat_counter.sv
module deframe_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         count <= '0;
    else if (clr)                       count <= '0;
    else if (inc && count != CNT_MAX)   count <= count + 1'b1;
  end

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

  assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count != CNT_MAX) |=> (count == CNT_W'($past(count) + 1'b1)));

endmodule

// File: rtl/deframe_checker.sv
module deframe_checker
  import deframe_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic             cnt_clr,
  output logic             left_valid,
  output logic [7:0]       left_data,
  output logic             right_valid,
  output logic [7:0]       right_data,
  output logic             audio_valid,
  output logic [7:0]       audio_data,
  output logic             res_valid,
  output logic             res_good,
  output logic             res_err_sum,
  output logic             res_err_frame,
  output logic             res_err_type,
  output logic [CNT_W-1:0] cnt_sum_err,
  output logic [CNT_W-1:0] cnt_frame_err,
  output logic [CNT_W-1:0] cnt_type_err
);

  logic                 pay_fire;
  sink_t                pay_sink;
  byte_t                pay_byte;
  logic [NUM_SINKS-1:0] sink_valid;
  byte_t                sink_data [NUM_SINKS];
  logic [NUM_ERRS-1:0]  err_inc;
  logic [CNT_W-1:0]     err_cnt [NUM_ERRS];

  deframe_parser u_parser (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_sop        (in_sop),
    .in_eop        (in_eop),
    .pay_fire      (pay_fire),
    .pay_sink      (pay_sink),
    .pay_byte      (pay_byte),
    .res_valid     (res_valid),
    .res_good      (res_good),
    .res_err_sum   (res_err_sum),
    .res_err_frame (res_err_frame),
    .res_err_type  (res_err_type)
  );

  deframe_router u_router (
    .clk        (clk),
    .rst_n      (rst_n),
    .pay_fire   (pay_fire),
    .pay_sink   (pay_sink),
    .pay_byte   (pay_byte),
    .sink_valid (sink_valid),
    .sink_data  (sink_data)
  );

  assign left_valid  = sink_valid[SINK_LEFT];
  assign right_valid = sink_valid[SINK_RIGHT];
  assign audio_valid = sink_valid[SINK_AUDIO];
  assign left_data   = sink_data[SINK_LEFT];
  assign right_data  = sink_data[SINK_RIGHT];
  assign audio_data  = sink_data[SINK_AUDIO];

  assign err_inc = {res_valid & res_err_type,
                    res_valid & res_err_frame,
                    res_valid & res_err_sum};

  for (genvar k = 0; k < NUM_ERRS; k++) begin : g_cnt
    deframe_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (err_inc[k]),
      .count (err_cnt[k])
    );
  end

  assign cnt_sum_err   = err_cnt[0];
  assign cnt_frame_err = err_cnt[1];
  assign cnt_type_err  = err_cnt[2];

  // R9: no output activity without an input beat the cycle before
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid || right_valid || audio_valid || res_valid) |-> $past(in_valid));

endmodule

// File: tb/deframe_checker_tb_top.sv
`timescale 1ns/1ps
module deframe_checker_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_sop = 1'b0;
  logic       in_eop = 1'b0;
  logic       cnt_clr = 1'b0;
  logic       left_valid, right_valid, audio_valid;
  logic [7:0] left_data, right_data, audio_data;
  logic       res_valid, res_good, res_err_sum, res_err_frame, res_err_type;
  logic [15:0] cnt_sum_err, cnt_frame_err, cnt_type_err;

  always #2 clk = ~clk;

  deframe_checker dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .cnt_clr(cnt_clr),
    .left_valid(left_valid), .left_data(left_data),
    .right_valid(right_valid), .right_data(right_data),
    .audio_valid(audio_valid), .audio_data(audio_data),
    .res_valid(res_valid), .res_good(res_good), .res_err_sum(res_err_sum),
    .res_err_frame(res_err_frame), .res_err_type(res_err_type),
    .cnt_sum_err(cnt_sum_err), .cnt_frame_err(cnt_frame_err),
    .cnt_type_err(cnt_type_err)
  );

  int checks = 0;
  int errors = 0;
  int exp_sum = 0, exp_frame = 0, exp_type = 0;
  logic [7:0] q_l[$], q_r[$], q_a[$];
  logic [3:0] q_res[$];
  string      q_tag[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sat_inc(int v);
    return (v >= 65535) ? 65535 : v + 1;
  endfunction

  function automatic logic [7:0] make_chk(int s);
    return 8'((256 - (s % 256)) % 256);
  endfunction

  function automatic bit is_known(logic [7:0] t);
    return (t == 8'h01) || (t == 8'h02) || (t == 8'h03);
  endfunction

  task automatic expect_res(bit g, bit s, bit f, bit t, string tag);
    q_res.push_back({g, s, f, t});
    q_tag.push_back(tag);
    if (s) exp_sum = sat_inc(exp_sum);
    if (f) exp_frame = sat_inc(exp_frame);
    if (t) exp_type = sat_inc(exp_type);
  endtask

  task automatic expect_byte(logic [7:0] t, logic [7:0] b);
    if (t == 8'h01) q_l.push_back(b);
    else if (t == 8'h02) q_r.push_back(b);
    else if (t == 8'h03) q_a.push_back(b);
  endtask

  task automatic beat(bit v, logic [7:0] d, bit s, bit e);
    @(posedge clk); #1;
    in_valid = v; in_data = d; in_sop = s; in_eop = e; cnt_clr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) beat(0, 8'h00, 0, 0);
  endtask

  task automatic clear_pulse();
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; cnt_clr = 1'b1;
    exp_sum = 0; exp_frame = 0; exp_type = 0;
  endtask

  task automatic send_packet(logic [7:0] typ, int len, bit bad, bit gaps, string tag);
    int s;
    logic [7:0] b, c;
    s = typ + len;
    beat(1, typ, 1, 0);
    if (gaps && ($urandom % 4 == 0)) idle(1);
    beat(1, 8'(len), 0, 0);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) idle(1);
      b = 8'($urandom);
      s += b;
      expect_byte(typ, b);
      beat(1, b, 0, 0);
    end
    c = make_chk(s);
    if (bad) c = c ^ 8'(1 + $urandom_range(0, 254));
    expect_res(!bad && is_known(typ), bad, 1'b0, !is_known(typ), tag);
    beat(1, c, 0, 1);
  endtask

  task automatic drain_and_check(string tag);
    idle(4);
    check(q_l.size() == 0 && q_r.size() == 0 && q_a.size() == 0, tag,
          "payload bytes missing", q_l.size() + q_r.size() + q_a.size(), 0);
    check(q_res.size() == 0, tag, "verdicts missing", q_res.size(), 0);
    check(int'(cnt_sum_err) == exp_sum, "R10", "cnt_sum_err", cnt_sum_err, exp_sum);
    check(int'(cnt_frame_err) == exp_frame, "R10", "cnt_frame_err", cnt_frame_err, exp_frame);
    check(int'(cnt_type_err) == exp_type, "R10", "cnt_type_err", cnt_type_err, exp_type);
  endtask

  // monitor: outputs sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] e;
      logic [3:0] r;
      string tg;
      if (left_valid || right_valid || audio_valid)
        check($countones({left_valid, right_valid, audio_valid}) == 1, "R2",
              "strobes not exclusive", {left_valid, right_valid, audio_valid}, 0);
      if (left_valid) begin
        if (q_l.size() == 0) check(0, "R2 R3 R9", "unexpected left byte", left_data, 0);
        else begin e = q_l.pop_front(); check(left_data == e, "R2", "left byte", left_data, e); end
      end
      if (right_valid) begin
        if (q_r.size() == 0) check(0, "R2 R3 R9", "unexpected right byte", right_data, 0);
        else begin e = q_r.pop_front(); check(right_data == e, "R2", "right byte", right_data, e); end
      end
      if (audio_valid) begin
        if (q_a.size() == 0) check(0, "R2 R3 R9", "unexpected audio byte", audio_data, 0);
        else begin e = q_a.pop_front(); check(audio_data == e, "R2", "audio byte", audio_data, e); end
      end
      if (res_valid) begin
        if (q_res.size() == 0) check(0, "R5 R9", "unexpected verdict",
                                     {res_good, res_err_sum, res_err_frame, res_err_type}, 0);
        else begin
          r = q_res.pop_front();
          tg = q_tag.pop_front();
          check({res_good, res_err_sum, res_err_frame, res_err_type} == r, tg,
                "verdict {good,sum,frame,type}",
                {res_good, res_err_sum, res_err_frame, res_err_type}, r);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240615));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check({left_valid, right_valid, audio_valid, res_valid, res_good} == 5'b0, "R12",
          "outputs after reset", {left_valid, right_valid, audio_valid, res_valid, res_good}, 0);
    check(cnt_sum_err == 0 && cnt_frame_err == 0 && cnt_type_err == 0, "R12",
          "counters after reset", cnt_sum_err + cnt_frame_err + cnt_type_err, 0);

    // R1 R4 R5: good packets of each sink, no gaps
    send_packet(8'h01, 6, 0, 0, "R1 R5");
    send_packet(8'h02, 3, 0, 0, "R1 R5");
    send_packet(8'h03, 4, 1, 0, "R4");
    // R13: zero length
    send_packet(8'h01, 0, 0, 0, "R13");
    send_packet(8'h03, 0, 1, 0, "R13 R4");
    // R1: maximum length
    send_packet(8'h03, 255, 0, 1, "R1");
    drain_and_check("R1");

    // R9: stray beats while idle, including a lone eop
    beat(1, 8'h01, 0, 0); beat(1, 8'h05, 0, 0); beat(1, 8'hAA, 0, 1); beat(1, 8'h00, 0, 0);
    drain_and_check("R9");

    // R3: unknown type with good and with bad checksum
    send_packet(8'h7E, 5, 0, 0, "R3");
    send_packet(8'h00, 2, 1, 0, "R3 R4");
    drain_and_check("R3");

    // R6: sop mid-payload, new packet starts on that beat
    beat(1, 8'h01, 1, 0); beat(1, 8'd5, 0, 0);
    expect_byte(8'h01, 8'h11); beat(1, 8'h11, 0, 0);
    expect_byte(8'h01, 8'h22); beat(1, 8'h22, 0, 0);
    expect_res(0, 0, 1, 0, "R6");
    send_packet(8'h02, 3, 0, 0, "R6");
    // R6: sop+eop in an open packet returns to idle
    beat(1, 8'h02, 1, 0); beat(1, 8'd4, 0, 0);
    expect_res(0, 0, 1, 0, "R6");
    beat(1, 8'h33, 1, 1);
    beat(1, 8'h44, 0, 0);
    send_packet(8'h03, 2, 0, 0, "R6");
    drain_and_check("R6");

    // R7: early eop on length and payload, sop+eop while idle
    beat(1, 8'h01, 1, 0);
    expect_res(0, 0, 1, 0, "R7");
    beat(1, 8'd3, 0, 1);
    beat(1, 8'h02, 1, 0); beat(1, 8'd3, 0, 0);
    expect_byte(8'h02, 8'h55); beat(1, 8'h55, 0, 0);
    expect_res(0, 0, 1, 0, "R7");
    beat(1, 8'h66, 0, 1);
    expect_res(0, 0, 1, 0, "R7");
    beat(1, 8'h01, 1, 1);
    drain_and_check("R7");

    // R8: checksum beat without eop, followers dropped
    beat(1, 8'h03, 1, 0); beat(1, 8'd1, 0, 0);
    expect_byte(8'h03, 8'h77); beat(1, 8'h77, 0, 0);
    expect_res(0, 0, 1, 0, "R8");
    beat(1, make_chk(8'h03 + 1 + 8'h77), 0, 0);
    beat(1, 8'h01, 0, 0); beat(1, 8'h09, 0, 1);
    send_packet(8'h01, 2, 0, 0, "R8");
    drain_and_check("R8");

    // random traffic with gaps and stray bytes
    for (int n = 0; n < 300; n++) begin
      int r;
      logic [7:0] t;
      r = $urandom % 8;
      case (r)
        0, 1, 7: t = 8'h01;
        2, 3:    t = 8'h02;
        4, 5:    t = 8'h03;
        default: t = 8'(8'h10 + $urandom % 200);
      endcase
      send_packet(t, $urandom % 24, ($urandom % 6) == 0, 1, "R2 R3 R4 R5");
      if ($urandom % 10 == 0) beat(1, 8'($urandom), 0, 0);
      if ($urandom % 3 == 0) idle(1);
    end
    drain_and_check("R2");

    // R10: saturation of the frame counter
    clear_pulse();
    idle(2);
    for (int n = 0; n < 65540; n++) begin
      expect_res(0, 0, 1, 0, "R10");
      beat(1, 8'h00, 1, 1);
    end
    drain_and_check("R10");
    check(cnt_frame_err == 16'hFFFF, "R10", "frame counter saturated", cnt_frame_err, 16'hFFFF);

    // R11: clear coincides with a due increment
    clear_pulse();
    idle(2);
    expect_res(0, 0, 1, 0, "R11");
    beat(1, 8'h00, 1, 1);
    clear_pulse();
    idle(4);
    check(cnt_frame_err == 0 && cnt_sum_err == 0 && cnt_type_err == 0, "R11",
          "counters after clear with pending increment", cnt_frame_err, 0);
    expect_res(0, 0, 1, 0, "R11");
    beat(1, 8'h00, 1, 1);
    drain_and_check("R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule